// File: doc/BRIEF.md
# Two-Context Coarse-Grain Thread Switch Controller

This controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that carries two hardware thread contexts. It picks which thread owns the pipeline and gives the pipeline to the other thread only when the owner hits an expensive event: a miss in the instruction cache during fetch, or a miss in the data cache during the memory stage. For each thread it keeps a program counter and a waiting flag. It drives the fetch address, a fetch-enable, the thread-select lines for the register bank and the address-translation context, and squash lines for the fetch, decode and execute slots.

A data miss is handled precisely. The controller keeps a thread tag and a valid bit for each instruction between decode and memory. When the memory stage reports a miss, only the younger instructions that belong to the missing thread are squashed. The missing thread is later restarted at the memory instruction that missed, so that instruction is executed again. The memory side raises a per-thread fill-done pulse when the miss has been serviced. Until that pulse arrives, the missing thread cannot be chosen again. If both threads are waiting, fetch stalls. A free-running cycle counter and a retired-instruction counter let the instructions-per-clock ratio be measured.

Top module: `thread_switch_ctrl`

## Requirements
- R1: In the first cycle after reset, thread 0 is active, fetch is enabled, the fetch address is the thread-0 reset PC, and both counters read 0. Thread 1 is ready at its own reset PC.
- R2: `rf_bank_o` and `xlat_ctx_o` always equal `act_tid_o`.
- R3: In every cycle where `fetch_en_o` is high and no miss is taken, the active thread's PC advances by PC_STEP. A thread's PC does not move while it is not fetching.
- R4: An instruction miss (`if_miss_i` while `fetch_en_o` is high) stores `if_pc_i` as the active thread's PC and marks that thread waiting. In the next cycle the other thread is active if it is not waiting. The instruction fetched in the miss cycle never reaches decode.
- R5: A data miss (`mem_miss_i` while the memory slot holds a valid instruction) sets `squash_o` in the same cycle. Bit 0 is fetch, bit 1 is decode and bit 2 is execute. A bit is set exactly when that slot holds an instruction of the missing thread. Squashed instructions never reach memory.
- R6: A data miss stores `mem_pc_i` as the missing thread's PC and marks that thread waiting. When the thread runs again, its first fetch address is that PC.
- R7: If an instruction miss and a data miss of the same thread fall in the same cycle, the data miss decides the saved PC.
- R8: A waiting thread is not selected until its `fill_done_i` bit has been seen. A miss in the same cycle as the fill keeps the thread waiting.
- R9: Ownership is coarse grained. While the active thread is not waiting, the active thread ID does not change, even if the other thread has become ready.
- R10: When both threads are waiting, `fetch_en_o` is low. The first thread whose fill arrives takes the pipeline. If both fills arrive together, the current ID is kept.
- R11: `mem_miss_i` has no effect when the memory slot is empty or its instruction was squashed.
- R12: `cycle_cnt_o` counts every clock after reset and `retire_cnt_o` counts `retire_i` pulses. With one instruction miss every 100 fetches and a 20-cycle fill, at least 97 instructions retire per 100 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_miss_i | input | 1 | Fetch of the current cycle missed the instruction cache |
| if_pc_i | input | PC_W | Address of the fetch that missed |
| mem_miss_i | input | 1 | Instruction in the memory stage missed the data cache |
| mem_pc_i | input | PC_W | Address of the instruction in the memory stage |
| fill_done_i | input | 2 | Per-thread pulse: outstanding miss serviced |
| retire_i | input | 1 | One instruction retired this cycle |
| act_tid_o | output | 1 | Thread owning the pipeline |
| fetch_en_o | output | 1 | Fetch this cycle is valid |
| fetch_pc_o | output | PC_W | Next fetch address of the active thread |
| squash_o | output | 3 | Kill fetch (bit 0), decode (bit 1), execute (bit 2) slot |
| rf_bank_o | output | 1 | General-register bank select |
| xlat_ctx_o | output | 1 | Address-translation context select |
| cycle_cnt_o | output | CNT_W | Cycles since reset |
| retire_cnt_o | output | CNT_W | Retired instructions since reset |

## Verification
Three events can land in one cycle: an instruction miss of the active thread, a data miss of the same thread or of the draining one, and a fill of either thread. Random stimulus produces these overlaps. Fill latency varies from 2 to 20 cycles, so both threads' fills can arrive together, and a spurious `mem_miss_i` is sometimes raised while the memory slot is empty. A behavioural model applies the R7 and R8 priorities and the R10 tie rule, and every output is compared with it on every clock. A second phase issues one instruction miss every 100 fetches and checks the retirement ratio.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int NUM_THR = 2;

    typedef logic tid_t;

    typedef enum int {
        SQ_IF = 0,
        SQ_ID = 1,
        SQ_EX = 2
    } sq_slot_e;

    localparam int NUM_SQ = 3;

    typedef struct packed {
        logic vld;
        tid_t tid;
    } slot_t;

    function automatic tid_t peer(input tid_t t);
        return ~t;
    endfunction

endpackage

// File: rtl/tsc_thread_ctx.sv
module tsc_thread_ctx
    import tsc_pkg::*;
#(
    parameter int             PC_W    = 32,
    parameter logic [PC_W-1:0] RST_PC = '0,
    parameter int             PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic            imiss,
    input  logic            dmiss,
    input  logic            fill,
    input  logic [PC_W-1:0] if_pc,
    input  logic [PC_W-1:0] mem_pc,
    output logic [PC_W-1:0] pc_o,
    output logic            wait_o,
    output logic            wait_nxt_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    logic [PC_W-1:0] pc_q, pc_d;
    logic            wait_q;

    assign wait_nxt_o = dmiss || imiss || (wait_q && !fill);

    always_comb begin
        pc_d = pc_q;
        if (dmiss)        pc_d = mem_pc;
        else if (imiss)   pc_d = if_pc;
        else if (advance) pc_d = pc_q + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= RST_PC;
            wait_q <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            wait_q <= wait_nxt_o;
        end
    end

    assign pc_o   = pc_q;
    assign wait_o = wait_q;
endmodule

// File: rtl/tsc_slot_track.sv
module tsc_slot_track
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  tid_t              act,
    input  logic              if_miss,
    input  logic              mem_miss,
    output logic [NUM_SQ-1:0] squash,
    output logic              dmiss_vld,
    output tid_t              dmiss_tid
);
    slot_t id_q, ex_q, mem_q;
    slot_t id_d, ex_d, mem_d;

    assign dmiss_vld = mem_miss && mem_q.vld;
    assign dmiss_tid = mem_q.tid;

    always_comb begin
        squash        = '0;
        squash[SQ_IF] = dmiss_vld && fetch_en && (act == dmiss_tid);
        squash[SQ_ID] = dmiss_vld && id_q.vld && (id_q.tid == dmiss_tid);
        squash[SQ_EX] = dmiss_vld && ex_q.vld && (ex_q.tid == dmiss_tid);

        id_d.vld  = fetch_en && !if_miss && !squash[SQ_IF];
        id_d.tid  = act;
        ex_d.vld  = id_q.vld && !squash[SQ_ID];
        ex_d.tid  = id_q.tid;
        mem_d.vld = ex_q.vld && !squash[SQ_EX];
        mem_d.tid = ex_q.tid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= '0;
            ex_q  <= '0;
            mem_q <= '0;
        end else begin
            id_q  <= id_d;
            ex_q  <= ex_d;
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/tsc_perf_cnt.sv
module tsc_perf_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire,
    output logic [CNT_W-1:0] cycles_o,
    output logic [CNT_W-1:0] retired_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cycles_o  <= '0;
            retired_o <= '0;
        end else begin
            cycles_o  <= cycles_o + 1'b1;
            retired_o <= retired_o + CNT_W'(retire);
        end
    end
endmodule

// File: rtl/thread_switch_ctrl.sv
module thread_switch_ctrl
    import tsc_pkg::*;
#(
    parameter int              PC_W    = 32,
    parameter int              CNT_W   = 32,
    parameter logic [PC_W-1:0] RST_PC0 = 32'h0000_1000,
    parameter logic [PC_W-1:0] RST_PC1 = 32'h0000_8000,
    parameter int              PC_STEP = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    if_miss_i,
    input  logic [PC_W-1:0]         if_pc_i,
    input  logic                    mem_miss_i,
    input  logic [PC_W-1:0]         mem_pc_i,
    input  logic [NUM_THR-1:0]      fill_done_i,
    input  logic                    retire_i,
    output logic                    act_tid_o,
    output logic                    fetch_en_o,
    output logic [PC_W-1:0]         fetch_pc_o,
    output logic [NUM_SQ-1:0]       squash_o,
    output logic                    rf_bank_o,
    output logic                    xlat_ctx_o,
    output logic [CNT_W-1:0]        cycle_cnt_o,
    output logic [CNT_W-1:0]        retire_cnt_o
);
    tid_t               act_q, act_d;
    logic [NUM_THR-1:0] wait_q, wait_nxt, imiss_hit, dmiss_hit;
    logic [PC_W-1:0]    pc_q [NUM_THR];
    logic               dmiss_vld;
    tid_t               dmiss_tid;
    logic               fetch_en;

    assign fetch_en = !wait_q[act_q];

    tsc_slot_track u_track (
        .clk       (clk),
        .rst       (rst),
        .fetch_en  (fetch_en),
        .act       (act_q),
        .if_miss   (if_miss_i),
        .mem_miss  (mem_miss_i),
        .squash    (squash_o),
        .dmiss_vld (dmiss_vld),
        .dmiss_tid (dmiss_tid)
    );

    for (genvar g = 0; g < NUM_THR; g++) begin : g_ctx
        assign dmiss_hit[g] = dmiss_vld && (dmiss_tid == tid_t'(g));
        assign imiss_hit[g] = fetch_en && if_miss_i && (act_q == tid_t'(g)) && !dmiss_hit[g];

        tsc_thread_ctx #(
            .PC_W    (PC_W),
            .RST_PC  ((g == 0) ? RST_PC0 : RST_PC1),
            .PC_STEP (PC_STEP)
        ) u_ctx (
            .clk        (clk),
            .rst        (rst),
            .advance    (fetch_en && (act_q == tid_t'(g))),
            .imiss      (imiss_hit[g]),
            .dmiss      (dmiss_hit[g]),
            .fill       (fill_done_i[g]),
            .if_pc      (if_pc_i),
            .mem_pc     (mem_pc_i),
            .pc_o       (pc_q[g]),
            .wait_o     (wait_q[g]),
            .wait_nxt_o (wait_nxt[g])
        );
    end

    // Hand over only when the owner is blocked and its peer is not.
    always_comb begin
        act_d = act_q;
        if (wait_nxt[act_q] && !wait_nxt[peer(act_q)])
            act_d = peer(act_q);
    end

    always_ff @(posedge clk) begin
        if (rst) act_q <= tid_t'(0);
        else     act_q <= act_d;
    end

    tsc_perf_cnt #(.CNT_W(CNT_W)) u_perf (
        .clk       (clk),
        .rst       (rst),
        .retire    (retire_i),
        .cycles_o  (cycle_cnt_o),
        .retired_o (retire_cnt_o)
    );

    assign act_tid_o  = act_q;
    assign fetch_en_o = fetch_en;
    assign fetch_pc_o = pc_q[act_q];
    assign rf_bank_o  = act_q;
    assign xlat_ctx_o = act_q;
endmodule

// File: rtl/tsc_ctrl_checker.sv
module tsc_ctrl_checker #(
    parameter int PC_W    = 32,
    parameter int CNT_W   = 32,
    parameter int PC_STEP = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             if_miss_i,
    input logic             mem_miss_i,
    input logic             act_tid_o,
    input logic             fetch_en_o,
    input logic [PC_W-1:0]  fetch_pc_o,
    input logic [2:0]       squash_o,
    input logic [CNT_W-1:0] cycle_cnt_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (fetch_en_o && !if_miss_i && !mem_miss_i) |=> $stable(act_tid_o));

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_en_o && !if_miss_i && !mem_miss_i) |=> (fetch_pc_o == $past(fetch_pc_o) + STEP));

    assert_imiss_leave_R4: assert property (@(posedge clk) disable iff (rst)
        (fetch_en_o && if_miss_i && !mem_miss_i) |=> (act_tid_o != $past(act_tid_o)) || !fetch_en_o);

    assert_squash_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (squash_o != 3'b000) |-> mem_miss_i);

    assert_cycle_count_R12: assert property (@(posedge clk) disable iff (rst)
        (cycle_cnt_o != '1) |=> (cycle_cnt_o == $past(cycle_cnt_o) + 1'b1));
endmodule

bind thread_switch_ctrl tsc_ctrl_checker #(
    .PC_W    (PC_W),
    .CNT_W   (CNT_W),
    .PC_STEP (PC_STEP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .if_miss_i   (if_miss_i),
    .mem_miss_i  (mem_miss_i),
    .act_tid_o   (act_tid_o),
    .fetch_en_o  (fetch_en_o),
    .fetch_pc_o  (fetch_pc_o),
    .squash_o    (squash_o),
    .cycle_cnt_o (cycle_cnt_o)
);

// File: tb/test_thread_switch_ctrl.sv
module test_thread_switch_ctrl;
    localparam int          PC_W  = 32;
    localparam int          CNT_W = 32;
    localparam logic [31:0] PC0   = 32'h0000_1000;
    localparam logic [31:0] PC1   = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        if_miss_i = 1'b0, mem_miss_i = 1'b0, retire_i = 1'b0;
    logic [31:0] if_pc_i = '0, mem_pc_i = '0;
    logic [1:0]  fill_done_i = '0;
    logic        act_tid_o, fetch_en_o, rf_bank_o, xlat_ctx_o;
    logic [31:0] fetch_pc_o, cycle_cnt_o, retire_cnt_o;
    logic [2:0]  squash_o;

    always #10 clk = ~clk;

    thread_switch_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W), .RST_PC0(PC0), .RST_PC1(PC1), .PC_STEP(4))
    i_thread_switch_ctrl (
        .clk(clk), .rst(rst), .if_miss_i(if_miss_i), .if_pc_i(if_pc_i),
        .mem_miss_i(mem_miss_i), .mem_pc_i(mem_pc_i), .fill_done_i(fill_done_i),
        .retire_i(retire_i), .act_tid_o(act_tid_o), .fetch_en_o(fetch_en_o),
        .fetch_pc_o(fetch_pc_o), .squash_o(squash_o), .rf_bank_o(rf_bank_o),
        .xlat_ctx_o(xlat_ctx_o), .cycle_cnt_o(cycle_cnt_o), .retire_cnt_o(retire_cnt_o)
    );

    int n_cmp = 0, n_bad = 0;

    // behavioural model state
    int          m_act, m_wbv, m_cyc, m_ret, n_fetch;
    int          m_wait [2];
    int          cd [2];
    logic [31:0] m_pc [2];
    int          sv [1:3], st [1:3];
    logic [31:0] sp [1:3];

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, got, exp, m_cyc);
        end
    endtask

    task automatic model_reset();
        m_act = 0; m_wbv = 0; m_cyc = 0; m_ret = 0; n_fetch = 0;
        for (int t = 0; t < 2; t++) begin m_wait[t] = 0; cd[t] = -1; end
        m_pc[0] = PC0; m_pc[1] = PC1;
        for (int s = 1; s <= 3; s++) begin sv[s] = 0; st[s] = 0; sp[s] = '0; end
    endtask

    task automatic do_reset();
        rst = 1'b1; if_miss_i = 0; mem_miss_i = 0; fill_done_i = 0; retire_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // mode 0: random overlaps, mode 1: one fetch miss per 100 fetches
    task automatic run(input int mode, input int cycles);
        for (int n = 0; n < cycles; n++) begin
            int fe, dv, dt, lat;
            int sq [3];
            int nw [2];
            logic [31:0] npc [2];
            int nact, n1v, n1t, n2v, n2t, n3v, n3t, nwb;
            logic [31:0] n1p, n2p, n3p;

            fe = (m_wait[m_act] == 0) ? 1 : 0;
            if (mode == 0) begin
                if_miss_i  = fe && ($urandom_range(0, 11) == 0);
                mem_miss_i = ($urandom_range(0, 9) == 0);
                lat        = $urandom_range(2, 20);
            end else begin
                if_miss_i  = fe && ((n_fetch % 100) == 99);
                mem_miss_i = 1'b0;
                lat        = 20;
            end
            if (fe) n_fetch++;
            if_pc_i  = m_pc[m_act];
            mem_pc_i = sv[3] ? sp[3] : $urandom();
            for (int t = 0; t < 2; t++) fill_done_i[t] = (cd[t] == 0);
            retire_i = (m_wbv != 0);
            #1;
            dv = (mem_miss_i && sv[3]) ? 1 : 0;
            dt = st[3];
            sq[0] = (dv && dt == m_act && fe) ? 1 : 0;
            sq[1] = (dv && sv[1] && st[1] == dt) ? 1 : 0;
            sq[2] = (dv && sv[2] && st[2] == dt) ? 1 : 0;

            if (m_cyc == 0) begin
                chk("R1 reset active thread", act_tid_o, 0);
                chk("R1 reset fetch enable", fetch_en_o, 1);
                chk("R1 reset fetch pc", fetch_pc_o, PC0);
                chk("R1 reset counters", {cycle_cnt_o, retire_cnt_o}, 0);
            end
            chk("R4/R8/R9 active thread", act_tid_o, m_act[0]);
            chk("R10 fetch enable", fetch_en_o, fe[0]);
            chk("R3/R6/R7 fetch pc", fetch_pc_o, m_pc[m_act]);
            chk("R5/R11 squash", squash_o, {sq[2][0], sq[1][0], sq[0][0]});
            chk("R2 bank and context select", {rf_bank_o, xlat_ctx_o}, {m_act[0], m_act[0]});
            chk("R12 cycle counter", cycle_cnt_o, m_cyc);
            chk("R12 retire counter", retire_cnt_o, m_ret);

            for (int t = 0; t < 2; t++) begin
                int dh, ih;
                dh = (dv && dt == t) ? 1 : 0;
                ih = (fe && if_miss_i && m_act == t && !dh) ? 1 : 0;
                nw[t] = (dh || ih || (m_wait[t] && !fill_done_i[t])) ? 1 : 0;
                if (dh)                       npc[t] = mem_pc_i;
                else if (ih)                  npc[t] = if_pc_i;
                else if (fe && m_act == t)    npc[t] = m_pc[t] + 32'd4;
                else                          npc[t] = m_pc[t];
                if (dh || ih)     cd[t] = lat;
                else if (cd[t] >= 0) cd[t] = cd[t] - 1;
            end
            nact = (nw[m_act] && !nw[1 - m_act]) ? 1 - m_act : m_act;
            n1v = (fe && !if_miss_i && !sq[0]) ? 1 : 0; n1t = m_act; n1p = m_pc[m_act];
            n2v = (sv[1] && !sq[1]) ? 1 : 0;            n2t = st[1]; n2p = sp[1];
            n3v = (sv[2] && !sq[2]) ? 1 : 0;            n3t = st[2]; n3p = sp[2];
            nwb = (sv[3] && !dv) ? 1 : 0;

            @(posedge clk);
            m_ret = m_ret + (retire_i ? 1 : 0);
            m_cyc++;
            for (int t = 0; t < 2; t++) begin m_wait[t] = nw[t]; m_pc[t] = npc[t]; end
            m_act = nact;
            sv[1] = n1v; st[1] = n1t; sp[1] = n1p;
            sv[2] = n2v; st[2] = n2t; sp[2] = n2p;
            sv[3] = n3v; st[3] = n3t; sp[3] = n3p;
            m_wbv = nwb;
            @(negedge clk);
        end
    endtask

    initial begin
        do_reset();
        run(0, 3000);
        do_reset();
        run(1, 2000);
        #1;
        // R12: one fetch miss per 100 fetches keeps throughput near one per cycle
        chk("R12 throughput ratio", (retire_cnt_o * 100 >= cycle_cnt_o * 97) ? 1 : 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule